// File: doc/BRIEF.md
# Computer-Operating-Properly Watchdog Controller

This block guards a small 8-bit microcontroller against runaway software. A free-running counter on the watchdog clock advances while the watchdog is active. If software does not service it within 2^CNT_W cycles, the block raises a system reset request. It holds that request for a fixed number of cycles and then starts counting again from zero.

Software reaches the block through one write-only byte register on the CPU bus. A write to it with the low bit at 0 services the watchdog. The same byte carries a sticky code-protection flag and an enable flag for optional features.

Two mask options set the behaviour. The first decides whether the watchdog exists at all. The second turns a STOP request from the core into HALT, so the watchdog keeps running through it. The core reports its power mode on separate lines. A comparator flag that reports a programming-level voltage on the interrupt pin turns the watchdog off for as long as that flag is high.

Top module: `cop_watchdog`

## Requirements
- R1: The control register answers only to bus writes at address REG_ADDR (default 16'h1FF0). In the written byte, bit 7 is the protection flag, bit 6 is the feature enable and bit 0 is the service bit. Writes to any other address change no flag and do not service the watchdog.
- R2: A register write with bit 0 equal to 0 clears the counter. With no further service, cop_reset rises exactly 2^CNT_W active clock edges after the edge that took the write (256 with defaults).
- R3: A register write with bit 0 equal to 1 leaves the counter running, so the timeout still falls 2^CNT_W edges after the last clear.
- R4: While opt_cop_en is 0, the counter stays at zero and cop_reset never rises.
- R5: With the watchdog enabled, the counter advances in run, wait and halt modes alike.
- R6: A STOP request with opt_stop_as_halt at 0 clears the counter and stops it, so no timeout occurs while it lasts.
- R7: With opt_stop_as_halt at 1, a STOP request is treated as halt and the counter keeps advancing to a timeout.
- R8: While hv_irq is 1, the watchdog is off and its counter is held at zero. Once hv_irq returns to 0, counting resumes from zero.
- R9: cop_reset stays high for exactly RST_HOLD cycles (default 4). It then falls, and the next timeout comes 2^CNT_W edges after it falls.
- R10: Writing 1 to the protection flag sets sec_bit. Later writes cannot clear it, and neither can rst; only por clears it. opt_bit follows each register write and is cleared by rst or por.
- R11: bus_rdata always reads as zero.
- R12: Asserting rst or por returns the counter to zero, so the next timeout falls 2^CNT_W edges after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Watchdog and bus clock |
| rst | input | 1 | Synchronous active-high system reset |
| por | input | 1 | Synchronous active-high power-on reset, also clears sec_bit |
| bus_wr | input | 1 | CPU bus write strobe |
| bus_rd | input | 1 | CPU bus read strobe |
| bus_addr | input | ADDR_W | CPU bus address |
| bus_wdata | input | 8 | CPU bus write data |
| bus_rdata | output | 8 | CPU bus read data, always zero |
| opt_cop_en | input | 1 | Mask option: watchdog present |
| opt_stop_as_halt | input | 1 | Mask option: treat STOP as HALT |
| mode_wait | input | 1 | Core is in wait mode |
| mode_halt | input | 1 | Core is in halt mode |
| mode_stop | input | 1 | Core requests stop mode |
| hv_irq | input | 1 | Programming-level voltage present on the interrupt pin |
| cop_reset | output | 1 | Registered watchdog reset request |
| sec_bit | output | 1 | Latched code-protection flag |
| opt_bit | output | 1 | Latched optional-features enable |

## Verification
The checker assumes that reset is asserted on the first clock edge and that rst and por are synchronous to clk. It also assumes that mask-option and mode lines change only between edges, so a timeout can be traced to the cycle just before it. The bench changes every input 2 ns after a rising edge and starts every scenario with a reset cycle. In each scenario the mode and option lines are either held steady or pulsed for exactly one cycle. Bus writes last exactly one edge, so the service clear and the flag updates land on a single known edge.

// File: rtl/cop_pkg.sv
package cop_pkg;
  // effective power mode seen by the watchdog
  typedef enum logic [1:0] {
    PM_RUN  = 2'd0,
    PM_WAIT = 2'd1,
    PM_HALT = 2'd2,
    PM_STOP = 2'd3
  } pmode_e;

  // counter state: counting or holding the reset request
  typedef enum logic {
    WD_COUNT = 1'b0,
    WD_HOLD  = 1'b1
  } wdst_e;

  // bit positions in the control byte (software-visible layout)
  localparam int SEC_POS = 7;
  localparam int OPT_POS = 6;
  localparam int SVC_POS = 0;
endpackage

// File: rtl/cop_regif.sv
module cop_regif
  import cop_pkg::*;
#(
  parameter int          ADDR_W   = 16,
  parameter logic [15:0] REG_ADDR = 16'h1FF0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              por,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic              sec_q,
  output logic              opt_q,
  output logic              svc
);
  localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(REG_ADDR);

  logic hit;
  logic unused_wdata;

  assign hit          = bus_wr && (bus_addr == HIT_ADDR);
  assign svc          = hit && !bus_wdata[SVC_POS];
  assign unused_wdata = ^bus_wdata[5:1];

  // protection flag: set-only, cleared by power-on reset alone
  always_ff @(posedge clk) begin
    if (por) begin
      sec_q <= 1'b0;
    end else if (hit && bus_wdata[SEC_POS]) begin
      sec_q <= 1'b1;
    end
  end

  // feature enable: follows every register write
  always_ff @(posedge clk) begin
    if (por || rst) begin
      opt_q <= 1'b0;
    end else if (hit) begin
      opt_q <= bus_wdata[OPT_POS];
    end
  end
endmodule

// File: rtl/cop_mode.sv
module cop_mode
  import cop_pkg::*;
(
  input  logic mode_wait,
  input  logic mode_halt,
  input  logic mode_stop,
  input  logic stop_as_halt,
  output logic count_gate
);
  pmode_e pm;

  always_comb begin
    if (mode_stop && !stop_as_halt) begin
      pm = PM_STOP;
    end else if (mode_stop || mode_halt) begin
      pm = PM_HALT;
    end else if (mode_wait) begin
      pm = PM_WAIT;
    end else begin
      pm = PM_RUN;
    end
  end

  // clock to the counter is gated only in true stop
  assign count_gate = (pm != PM_STOP);
endmodule

// File: rtl/cop_counter.sv
module cop_counter
  import cop_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int RST_HOLD = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic svc,
  output logic req
);
  localparam int              HW      = (RST_HOLD > 1) ? $clog2(RST_HOLD) : 1;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [HW-1:0]    H_LAST  = HW'(RST_HOLD - 1);

  wdst_e            st;
  logic [CNT_W-1:0] cnt;
  logic [HW-1:0]    hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= WD_COUNT;
      cnt  <= '0;
      hold <= '0;
      req  <= 1'b0;
    end else begin
      case (st)
        WD_COUNT: begin
          if (!run || svc) begin
            cnt <= '0;
          end else if (cnt == CNT_MAX) begin
            cnt  <= '0;
            hold <= '0;
            req  <= 1'b1;
            st   <= WD_HOLD;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        WD_HOLD: begin
          cnt <= '0;
          if (hold == H_LAST) begin
            req <= 1'b0;
            st  <= WD_COUNT;
          end else begin
            hold <= hold + 1'b1;
          end
        end
        default: st <= WD_COUNT;
      endcase
    end
  end
endmodule

// File: rtl/cop_watchdog.sv
module cop_watchdog
  import cop_pkg::*;
#(
  parameter int          ADDR_W   = 16,
  parameter logic [15:0] REG_ADDR = 16'h1FF0,
  parameter int          CNT_W    = 8,
  parameter int          RST_HOLD = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              por,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              opt_cop_en,
  input  logic              opt_stop_as_halt,
  input  logic              mode_wait,
  input  logic              mode_halt,
  input  logic              mode_stop,
  input  logic              hv_irq,
  output logic              cop_reset,
  output logic              sec_bit,
  output logic              opt_bit
);
  logic svc;
  logic gate;
  logic run;
  logic any_rst;
  logic unused_rd;

  assign unused_rd = bus_rd;
  assign bus_rdata = '0;
  assign any_rst   = rst || por;
  assign run       = opt_cop_en && !hv_irq && gate;

  cop_regif #(
    .ADDR_W  (ADDR_W),
    .REG_ADDR(REG_ADDR)
  ) u_regif (
    .clk      (clk),
    .rst      (rst),
    .por      (por),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .sec_q    (sec_bit),
    .opt_q    (opt_bit),
    .svc      (svc)
  );

  cop_mode u_mode (
    .mode_wait   (mode_wait),
    .mode_halt   (mode_halt),
    .mode_stop   (mode_stop),
    .stop_as_halt(opt_stop_as_halt),
    .count_gate  (gate)
  );

  cop_counter #(
    .CNT_W   (CNT_W),
    .RST_HOLD(RST_HOLD)
  ) u_cnt (
    .clk(clk),
    .rst(any_rst),
    .run(run),
    .svc(svc),
    .req(cop_reset)
  );
endmodule

// File: rtl/cop_watchdog_chk.sv
module cop_watchdog_chk #(
  parameter int          ADDR_W   = 16,
  parameter logic [15:0] REG_ADDR = 16'h1FF0,
  parameter int          RST_HOLD = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              por,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [7:0]        bus_wdata,
  input logic              opt_cop_en,
  input logic              opt_stop_as_halt,
  input logic              mode_stop,
  input logic              hv_irq,
  input logic              cop_reset,
  input logic              sec_bit,
  input logic              opt_bit
);
  logic      svc_wr;
  logic      any_rst;
  int unsigned hi_run;

  assign any_rst = rst || por;
  assign svc_wr  = bus_wr && (bus_addr == ADDR_W'(REG_ADDR)) && !bus_wdata[0];

  always_ff @(posedge clk) begin
    if (any_rst || !cop_reset) hi_run <= 0;
    else                       hi_run <= hi_run + 1;
  end

  // R2
  svc_blocks_timeout_chk: assert property (@(posedge clk) disable iff (any_rst)
    $rose(cop_reset) |-> !$past(svc_wr));

  // R4
  enable_needed_chk: assert property (@(posedge clk) disable iff (any_rst)
    $rose(cop_reset) |-> $past(opt_cop_en));

  // R6
  stop_blocks_timeout_chk: assert property (@(posedge clk) disable iff (any_rst)
    $rose(cop_reset) |-> !$past(mode_stop && !opt_stop_as_halt));

  // R8
  hv_blocks_timeout_chk: assert property (@(posedge clk) disable iff (any_rst)
    $rose(cop_reset) |-> !$past(hv_irq));

  // R9
  hold_bound_chk: assert property (@(posedge clk) disable iff (any_rst)
    cop_reset |-> (hi_run < RST_HOLD));

  // R10
  sec_sticky_chk: assert property (@(posedge clk) disable iff (por)
    sec_bit |=> sec_bit);

  // R10
  opt_reset_chk: assert property (@(posedge clk)
    any_rst |=> !opt_bit);
endmodule

bind cop_watchdog cop_watchdog_chk #(
  .ADDR_W  (ADDR_W),
  .REG_ADDR(REG_ADDR),
  .RST_HOLD(RST_HOLD)
) u_chk (
  .clk             (clk),
  .rst             (rst),
  .por             (por),
  .bus_wr          (bus_wr),
  .bus_addr        (bus_addr),
  .bus_wdata       (bus_wdata),
  .opt_cop_en      (opt_cop_en),
  .opt_stop_as_halt(opt_stop_as_halt),
  .mode_stop       (mode_stop),
  .hv_irq          (hv_irq),
  .cop_reset       (cop_reset),
  .sec_bit         (sec_bit),
  .opt_bit         (opt_bit)
);

// File: tb/cop_watchdog_tb.sv
module cop_watchdog_tb;
  localparam int          ADDR_W = 16;
  localparam logic [15:0] RADDR  = 16'h1FF0;
  localparam int          HOLD   = 4;
  localparam int          TMO    = 256;

  // {en, swait, hv, mode[1:0], cycles[9:0], expected cop_reset}
  // mode: 0 run, 1 wait, 2 halt, 3 stop
  localparam int NV = 10;
  localparam logic [15:0] VEC [NV] = '{
    {1'b1, 1'b0, 1'b0, 2'd0, 10'd255, 1'b0},  // R2 one edge short
    {1'b1, 1'b0, 1'b0, 2'd0, 10'd256, 1'b1},  // R2 timeout
    {1'b1, 1'b0, 1'b0, 2'd1, 10'd256, 1'b1},  // R5 wait
    {1'b1, 1'b0, 1'b0, 2'd2, 10'd256, 1'b1},  // R5 halt
    {1'b1, 1'b0, 1'b0, 2'd2, 10'd255, 1'b0},  // R5 halt short
    {1'b1, 1'b0, 1'b0, 2'd3, 10'd600, 1'b0},  // R6 stop
    {1'b1, 1'b1, 1'b0, 2'd3, 10'd256, 1'b1},  // R7 stop as halt
    {1'b1, 1'b0, 1'b1, 2'd0, 10'd600, 1'b0},  // R8 high voltage
    {1'b0, 1'b0, 1'b0, 2'd0, 10'd600, 1'b0},  // R4 disabled
    {1'b0, 1'b1, 1'b0, 2'd2, 10'd600, 1'b0}   // R4 disabled, halt
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              por = 1'b1;
  logic              bus_wr = 1'b0;
  logic              bus_rd = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [7:0]        bus_wdata = '0;
  logic [7:0]        bus_rdata;
  logic              opt_cop_en = 1'b1;
  logic              opt_stop_as_halt = 1'b0;
  logic              mode_wait = 1'b0;
  logic              mode_halt = 1'b0;
  logic              mode_stop = 1'b0;
  logic              hv_irq = 1'b0;
  logic              cop_reset;
  logic              sec_bit;
  logic              opt_bit;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  cop_watchdog u_dut (
    .clk(clk), .rst(rst), .por(por), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .opt_cop_en(opt_cop_en), .opt_stop_as_halt(opt_stop_as_halt),
    .mode_wait(mode_wait), .mode_halt(mode_halt), .mode_stop(mode_stop),
    .hv_irq(hv_irq), .cop_reset(cop_reset), .sec_bit(sec_bit), .opt_bit(opt_bit)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic restart();
    rst = 1'b1;
    step(1);
    rst = 1'b0;
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    step(1);
    bus_wr = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    step(2);
    // R12 reset state
    check({7'd0, cop_reset}, 8'd0, "R12 reset cop_reset");
    check({7'd0, sec_bit},   8'd0, "R10 reset sec_bit");
    check({7'd0, opt_bit},   8'd0, "R10 reset opt_bit");
    por = 1'b0;

    for (int i = 0; i < NV; i++) begin
      opt_cop_en       = VEC[i][15];
      opt_stop_as_halt = VEC[i][14];
      hv_irq           = VEC[i][13];
      mode_wait        = (VEC[i][12:11] == 2'd1);
      mode_halt        = (VEC[i][12:11] == 2'd2);
      mode_stop        = (VEC[i][12:11] == 2'd3);
      restart();
      step(int'(VEC[i][10:1]));
      check({7'd0, cop_reset}, {7'd0, VEC[i][0]}, $sformatf("R2/R4/R5/R6/R7/R8 vector %0d", i));
    end
    opt_cop_en = 1'b1; opt_stop_as_halt = 1'b0; hv_irq = 1'b0;
    mode_wait = 1'b0; mode_halt = 1'b0; mode_stop = 1'b0;

    // R2 service write mid-count
    restart(); step(99); wr(RADDR, 8'h00);
    step(TMO - 1); check({7'd0, cop_reset}, 8'd0, "R2 serviced early");
    step(1);       check({7'd0, cop_reset}, 8'd1, "R2 serviced timeout");

    // R9 hold length and restart
    step(HOLD - 1); check({7'd0, cop_reset}, 8'd1, "R9 hold still high");
    step(1);        check({7'd0, cop_reset}, 8'd0, "R9 hold released");
    step(TMO - 1);  check({7'd0, cop_reset}, 8'd0, "R9 next timeout early");
    step(1);        check({7'd0, cop_reset}, 8'd1, "R9 next timeout");

    // R3 write with service bit set
    restart(); step(99); wr(RADDR, 8'h01);
    step(TMO - 101); check({7'd0, cop_reset}, 8'd0, "R3 not serviced early");
    step(1);         check({7'd0, cop_reset}, 8'd1, "R3 not serviced timeout");

    // R1 service to another address is ignored
    restart(); step(99); wr(RADDR + 16'd1, 8'h00);
    step(TMO - 100); check({7'd0, cop_reset}, 8'd1, "R1 wrong address no service");

    // R6 one-cycle stop
    restart(); step(200); mode_stop = 1'b1; step(1); mode_stop = 1'b0;
    step(TMO - 1); check({7'd0, cop_reset}, 8'd0, "R6 stop cleared early");
    step(1);       check({7'd0, cop_reset}, 8'd1, "R6 stop cleared timeout");

    // R8 one-cycle high voltage
    restart(); step(200); hv_irq = 1'b1; step(1); hv_irq = 1'b0;
    step(TMO - 1); check({7'd0, cop_reset}, 8'd0, "R8 hv cleared early");
    step(1);       check({7'd0, cop_reset}, 8'd1, "R8 hv cleared timeout");

    // R12 reset mid-count
    restart(); step(200); restart();
    step(TMO - 1); check({7'd0, cop_reset}, 8'd0, "R12 reset restart early");
    step(1);       check({7'd0, cop_reset}, 8'd1, "R12 reset restart timeout");

    // R10 / R1 register flags
    restart();
    wr(RADDR, 8'h80); check({7'd0, sec_bit}, 8'd1, "R10 sec set");
    wr(RADDR, 8'h00); check({7'd0, sec_bit}, 8'd1, "R10 sec sticky");
    wr(RADDR, 8'h40); check({7'd0, opt_bit}, 8'd1, "R10 opt set");
    wr(RADDR + 16'd2, 8'h00); check({7'd0, opt_bit}, 8'd1, "R1 wrong address keeps opt");
    por = 1'b1; step(1); por = 1'b0;
    wr(RADDR + 16'd2, 8'hC0);
    check({6'd0, sec_bit, opt_bit}, 8'd0, "R1 wrong address sets nothing");
    wr(RADDR, 8'hC1); check({6'd0, sec_bit, opt_bit}, 8'd3, "R1 both flags set");
    wr(RADDR, 8'h01); check({7'd0, opt_bit}, 8'd0, "R10 opt cleared by write");
    wr(RADDR, 8'h40); restart();
    check({6'd0, sec_bit, opt_bit}, 8'd2, "R10 rst keeps sec clears opt");

    // R11 reads return zero
    bus_rd = 1'b1; bus_addr = RADDR; step(1);
    check(bus_rdata, 8'd0, "R11 read zero");
    bus_rd = 1'b0;

    por = 1'b1; step(1); por = 1'b0;
    check({7'd0, sec_bit}, 8'd0, "R10 por clears sec");

    finish_run();
  end
endmodule